// File: doc/BRIEF.md
# Dual-Enable Timebase Watchdog

This block is a memory-mapped watchdog with two counters. The first is a timebase that counts up on every clock cycle from reset onward. The second is an interval counter that advances only while the watchdog is armed. The interval length is 2^N clock cycles, and N is a build parameter.

When the interval ends for the first time, the block sets a timeout flag and pulses an interrupt. If the flag is still set when the next interval ends, the block pulses a reset output and latches a sticky reset flag.

Software services the watchdog by writing one to the timeout flag. That write clears the flag and starts the interval again from zero.

The watchdog is armed when either of two enable bits is set. The two bits sit in different words, so a single stray write cannot disarm it. A build option locks both enable bits once the watchdog is running.

The register bus is a plain single-cycle interface with byte addresses. Bits [3:2] select one of three words:

| Offset | Contents |
|--------|----------|
| 0x0 | Control word A |
| 0x4 | Control word B |
| 0x8 | Timebase count, read-only |

Reads are combinational from the address.

Top module: `wdog_dual_en`

## Requirements
- R1: After reset, words 0x0 and 0x4 read zero, and the interrupt and reset outputs are low.
- R2: The timebase word at 0x8 increases by exactly one per clock cycle, whether the watchdog is armed or not.
- R3: Control word A bit 1 is enable A, and control word B bit 0 is enable B. The watchdog runs while either bit is set, and it stops only when both are clear.
- R4: The first expiry comes 2^N cycles after arming or after the last restart. It sets the timeout flag, which reads as word A bit 2, and produces a one-cycle interrupt pulse.
- R5: An expiry that finds the timeout flag already set does two things. It produces a one-cycle reset pulse, and it sets the reset flag, which reads as word A bit 3. The reset flag stays set until software clears it.
- R6: Writing one to word A bit 3 or bit 2 clears that flag, and writing zero leaves it unchanged. Writing one to bit 2 also restarts the interval from zero. Every write to word A loads enable A from bit 1.
- R7: A restart written in the same cycle as an expiry wins. No pulse is produced, the timeout flag ends clear, and the next expiry comes a full interval after the write.
- R8: With the enable-once option set, writes cannot clear either enable bit once the watchdog is running, and the watchdog keeps timing.
- R9: While the watchdog is stopped, the interval counter holds and no pulse is produced, and both flags keep their values. Writes to offset 0x8 are ignored, and the unmapped offset 0xC reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed word |
| wdt_irq_o | output | 1 | One-cycle pulse at the first expiry |
| wdt_rst_o | output | 1 | One-cycle pulse at the second expiry |

## Verification
Two functions can fall in the same cycle: a software restart and the expiry of the interval. The bench provokes this by counting clock edges from the previous restart and timing a write of one to the timeout bit so that it lands on the edge where the second-expiry reset would be registered.

The scoreboard queue predicts what follows. It expects no reset pulse at that edge and one interrupt exactly one interval later. Register reads confirm that the timeout flag is clear just after the write and that the reset flag never set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WIDX_CTRL_A = 2'd0,
    WIDX_CTRL_B = 2'd1,
    WIDX_TBASE  = 2'd2,
    WIDX_NONE   = 2'd3
  } widx_e;

  localparam int unsigned BIT_RSTF  = 3;
  localparam int unsigned BIT_TOUT  = 2;
  localparam int unsigned BIT_EN_A  = 1;
  localparam int unsigned BIT_EN_B  = 0;
  localparam int unsigned CTRL_BITS = 4;
endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else         count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int unsigned LOG2 = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam logic [LOG2-1:0] LAST = '1;

  logic [LOG2-1:0] cnt_q;

  // held at zero while stopped, so arming restarts the interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || kick_i)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !kick_i && (cnt_q == LAST);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_a_i,
  input  logic                 wr_b_i,
  input  logic [CTRL_BITS-1:0] wdata_i,
  input  logic                 expire_i,
  output logic                 running_o,
  output logic                 kick_o,
  output logic                 en_a_o,
  output logic                 en_b_o,
  output logic                 tout_o,
  output logic                 rstf_o,
  output logic                 irq_o,
  output logic                 rst_o
);
  logic lock;
  logic en_a_d, en_b_d;
  logic first_exp, second_exp;

  generate
    if (ENABLE_ONCE) begin : g_once
      assign lock = running_o;
    end else begin : g_free
      assign lock = 1'b0;
    end
  endgenerate

  assign running_o  = en_a_o || en_b_o;
  assign kick_o     = wr_a_i && wdata_i[BIT_TOUT];
  assign first_exp  = expire_i && !tout_o;
  assign second_exp = expire_i && tout_o;

  always_comb begin
    en_a_d = en_a_o;
    en_b_d = en_b_o;
    if (wr_a_i) en_a_d = lock ? (en_a_o || wdata_i[BIT_EN_A]) : wdata_i[BIT_EN_A];
    if (wr_b_i) en_b_d = lock ? (en_b_o || wdata_i[BIT_EN_B]) : wdata_i[BIT_EN_B];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_a_o <= 1'b0;
      en_b_o <= 1'b0;
      tout_o <= 1'b0;
      rstf_o <= 1'b0;
      irq_o  <= 1'b0;
      rst_o  <= 1'b0;
    end else begin
      en_a_o <= en_a_d;
      en_b_o <= en_b_d;
      irq_o  <= first_exp;
      rst_o  <= second_exp;
      if (kick_o)         tout_o <= 1'b0;
      else if (first_exp) tout_o <= 1'b1;
      // a reset event is never lost to a simultaneous clear
      if (second_exp)                         rstf_o <= 1'b1;
      else if (wr_a_i && wdata_i[BIT_RSTF])   rstf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_dual_en.sv
module wdog_dual_en
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned TIMEOUT_LOG2 = 8,
  parameter bit          ENABLE_ONCE  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wdt_irq_o,
  output logic              wdt_rst_o
);
  widx_e             widx;
  logic              wr_a, wr_b;
  logic              running, kick, expire;
  logic              en_a, en_b, flag_tout, flag_rst;
  logic [DATA_W-1:0] tbase;
  logic              unused_bits;

  assign widx        = widx_e'(bus_addr_i[3:2]);
  assign wr_a        = bus_req_i && bus_we_i && (widx == WIDX_CTRL_A);
  assign wr_b        = bus_req_i && bus_we_i && (widx == WIDX_CTRL_B);
  assign unused_bits = ^{bus_wdata_i[DATA_W-1:CTRL_BITS], bus_addr_i[1:0]};

  wdog_timebase #(.W(DATA_W)) u_tbase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_o (tbase)
  );

  wdog_interval #(.LOG2(TIMEOUT_LOG2)) u_interval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (running),
    .kick_i   (kick),
    .expire_o (expire)
  );

  wdog_ctrl #(.ENABLE_ONCE(ENABLE_ONCE)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_a_i    (wr_a),
    .wr_b_i    (wr_b),
    .wdata_i   (bus_wdata_i[CTRL_BITS-1:0]),
    .expire_i  (expire),
    .running_o (running),
    .kick_o    (kick),
    .en_a_o    (en_a),
    .en_b_o    (en_b),
    .tout_o    (flag_tout),
    .rstf_o    (flag_rst),
    .irq_o     (wdt_irq_o),
    .rst_o     (wdt_rst_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (widx)
      WIDX_CTRL_A: begin
        bus_rdata_o[BIT_RSTF] = flag_rst;
        bus_rdata_o[BIT_TOUT] = flag_tout;
        bus_rdata_o[BIT_EN_A] = en_a;
      end
      WIDX_CTRL_B: bus_rdata_o[BIT_EN_B] = en_b;
      WIDX_TBASE:  bus_rdata_o = tbase;
      default:     bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_dual_en_chk.sv
module wdog_dual_en_chk #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter bit          ENABLE_ONCE = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              wdt_irq_o,
  input logic              wdt_rst_o,
  input logic              running_i,
  input logic              tout_i,
  input logic              rstf_i
);
  logic wr_a, clr_rstf, kick;
  assign wr_a     = bus_req_i && bus_we_i && (bus_addr_i[3:2] == 2'd0);
  assign clr_rstf = wr_a && bus_wdata_i[3];
  assign kick     = wr_a && bus_wdata_i[2];

  a_r4_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_irq_o |=> !wdt_irq_o);
  a_r4_irq_sets_tout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_irq_o |-> tout_i);
  a_r5_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
  a_r5_rst_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> rstf_i);
  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rstf_i && !clr_rstf) |=> rstf_i);
  a_r7_kick_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> (!tout_i && !wdt_irq_o && !wdt_rst_o));
  a_r8_once_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ENABLE_ONCE && running_i) |=> running_i);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |=> (!wdt_irq_o && !wdt_rst_o));
endmodule

bind wdog_dual_en wdog_dual_en_chk #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .ENABLE_ONCE (ENABLE_ONCE)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .wdt_irq_o   (wdt_irq_o),
  .wdt_rst_o   (wdt_rst_o),
  .running_i   (running),
  .tout_i      (flag_tout),
  .rstf_i      (flag_rst)
);

// File: tb/wdog_dual_en_tb_top.sv
module wdog_dual_en_tb_top;
  localparam int LG = 4;
  localparam int T  = 1 << LG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_a = 1'b0, req_b = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, rst_a, irq_b, rst_b;

  always #5 clk = ~clk;

  wdog_dual_en #(.TIMEOUT_LOG2(LG), .ENABLE_ONCE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req_a), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_a),
    .wdt_irq_o(irq_a), .wdt_rst_o(rst_a));

  wdog_dual_en #(.TIMEOUT_LOG2(LG), .ENABLE_ONCE(1'b1)) dut_once_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req_b), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_b),
    .wdt_irq_o(irq_b), .wdt_rst_o(rst_b));

  int cyc = 0;
  int checks = 0, fails = 0;
  int q_at[$];
  bit q_rst[$];
  bit once_irq_seen = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(bit is_rst, int at);
    q_rst.push_back(is_rst);
    q_at.push_back(at);
  endtask

  // caller sits at a negedge; the write lands on the next edge, returned as stamp
  task automatic wr(bit sel, logic [3:0] a, logic [31:0] d, output int stamp);
    req_a = !sel; req_b = sel; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0; we = 1'b0;
    stamp = cyc;
  endtask

  task automatic rd(bit sel, logic [3:0] a, output logic [31:0] d);
    req_a = !sel; req_b = sel; we = 1'b0; addr = a;
    #1;
    d = sel ? rdata_b : rdata_a;
    req_a = 1'b0; req_b = 1'b0;
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  // scoreboard monitor for the plain instance
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_b) once_irq_seen <= 1'b1;
      if (irq_a || rst_a) begin
        checks++;
        if (q_at.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected pulse actual=irq%0d/rst%0d@%0d expected=none",
                   irq_a, rst_a, cyc);
        end else begin
          if (q_at[0] != cyc || q_rst[0] != rst_a) begin
            fails++;
            $display("FAIL %s pulse actual=rst%0d@%0d expected=rst%0d@%0d",
                     q_rst[0] ? "R5" : "R4", rst_a, cyc, q_rst[0], q_at[0]);
          end
          void'(q_at.pop_front());
          void'(q_rst.pop_front());
        end
      end else if (q_at.size() > 0 && q_at[0] <= cyc) begin
        checks++;
        fails++;
        $display("FAIL %s missing pulse actual=none expected=rst%0d@%0d",
                 q_rst[0] ? "R5" : "R4", q_rst[0], q_at[0]);
        void'(q_at.pop_front());
        void'(q_rst.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, t0, t1;
    int s, w, k, k2, c, e, o;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 4'h0, v); chk("R1 word A", v, 0);
    rd(0, 4'h4, v); chk("R1 word B", v, 0);
    chk("R1 outputs", {30'd0, irq_a, rst_a}, 0);

    // R2 timebase, R9 write to it ignored, unmapped reads zero
    rd(0, 4'h8, t0);
    wr(0, 4'h8, 32'h0, s);
    rd(0, 4'h8, t1);
    chk("R2 R9 timebase step", t1, t0 + 1);
    rd(0, 4'hC, v); chk("R9 unmapped", v, 0);

    // start with both enables: irq one interval later, reset one after that
    wr(0, 4'h0, 32'h2, w);
    wr(0, 4'h4, 32'h1, s);
    push(1'b0, w + T);
    push(1'b1, w + 2 * T);
    rd(0, 4'h0, v); chk("R3 enable A", v, 32'h2);
    wait_to(w + 2 * T + 2);
    rd(0, 4'h0, v); chk("R5 flags after reset", v, 32'hE);
    rd(0, 4'h4, v); chk("R3 enable B", v, 32'h1);

    // R6 clear both flags and restart, then restart again before expiry
    wr(0, 4'h0, 32'hE, k);
    wait_to(k + 9);
    wr(0, 4'h0, 32'h4, k2);        // clears enable A, B keeps it running
    push(1'b0, k2 + T);
    rd(0, 4'h0, v); chk("R6 flags cleared", v, 32'h0);
    wait_to(k2 + T + 1);
    rd(0, 4'h0, v); chk("R4 timeout flag", v, 32'h4);

    // R7 restart on the edge of the second expiry
    wait_to(k2 + 2 * T - 1);
    wr(0, 4'h0, 32'h4, c);
    chk("R7 write edge", c, k2 + 2 * T);
    push(1'b0, c + T);
    rd(0, 4'h0, v); chk("R7 flag clear, no reset", v, 32'h0);
    wait_to(c + T + 1);
    rd(0, 4'h0, v); chk("R7 next irq full interval", v, 32'h4);

    // R6 writing zero leaves flags; R9 stop, nothing fires
    wr(0, 4'h0, 32'h0, s);
    rd(0, 4'h0, v); chk("R6 zero write", v, 32'h4);
    wr(0, 4'h4, 32'h0, s);
    wait_to(s + 3 * T);
    chk("R9 no pending pulses", q_at.size(), 0);
    rd(0, 4'h0, v); chk("R9 flags held", v, 32'h4);
    rd(0, 4'h4, v); chk("R3 enable B clear", v, 32'h0);

    // R3 enable A alone arms it
    wr(0, 4'h0, 32'h4, s);
    wr(0, 4'h0, 32'h2, e);
    push(1'b0, e + T);
    wait_to(e + T + 1);
    rd(0, 4'h0, v); chk("R3 enable A alone", v, 32'h6);
    wr(0, 4'h0, 32'h4, s);
    wait_to(s + 3 * T);
    chk("R3 both clear stops", q_at.size(), 0);

    // R8 enable-once instance
    wr(1, 4'h0, 32'h2, o);
    wr(1, 4'h4, 32'h1, s);
    wr(1, 4'h0, 32'h0, s);
    wr(1, 4'h4, 32'h0, s);
    rd(1, 4'h0, v); chk("R8 enable A locked", v & 32'h2, 32'h2);
    rd(1, 4'h4, v); chk("R8 enable B locked", v, 32'h1);
    wait_to(o + T + 2);
    chk("R8 still timing", {31'd0, once_irq_seen}, 1);

    summary();
    $finish;
  end
endmodule